// File: doc/BRIEF.md
# Quadrature Position Counter with Preset and Single-Shot Latch

The block counts position from two quadrature inputs, A and B, and can take a snapshot of the count on a pulse at a third input, C. A host drives it with an 8-bit control byte and a preset word, and reads back an 8-bit status byte, the live count, the latched count and a byte that mirrors the current input levels. All three inputs are asynchronous. They pass through a two-flop synchronizer before any edge is detected.

In normal operation (control bit 7 low), three control bits act on the block. A rising edge on bit 2 loads the preset word into the counter. Bit 0 arms the latch for exactly one C pulse. Bit 1 requests period measurement, and the block only acknowledges that request. The status byte acknowledges each action and carries sticky wrap flags. A separate static input selects count/direction mode in place of quadrature decoding. That mode turns the latch off.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is held, and just after it is released, the count, the latched value, the level byte and every status bit read zero.
- R2: In quadrature mode, each single change of synchronized A or B moves the count by one. The count rises when A leads B, following the (A,B) order 00,10,11,01. It falls in the reverse order. A change of both inputs at once is ignored. The new count is visible after the third rising clock edge that follows the input change.
- R3: An up-step from the all-ones count wraps to 0 and sets status bit 4. A down-step from 0 wraps to all ones and sets status bit 3. Both bits stay set until the next preset load.
- R4: A 0-to-1 change of control bit 2 loads `preset_data` into the count and clears status bits 4 and 3. Holding bit 2 high does not load again. A load wins over a count step on the same edge.
- R5: Status bit 2 goes high on the edge that performs the load. It stays high while control bit 2 is high, and it goes low one edge after control bit 2 is low.
- R6: While control bit 0 is high and status bit 0 is low, the first synchronized rising edge of C copies the count into `latch_value` and sets status bit 0. Later C edges leave `latch_value` unchanged while bit 0 stays high. If capture and load fall on the same edge, the latch receives the count from before the load.
- R7: A low control bit 0 clears status bit 0 and re-arms the latch for the next time bit 0 is set. `latch_value` keeps its contents.
- R8: When `vr_mode` is high, each rising edge of A counts once: up when B is low, down when B is high. In this mode C never sets status bit 0.
- R9: Status bit 1 takes the value of control bit 1 one edge later.
- R10: While control bit 7 is high, control bits 2, 1 and 0 have no effect: status bits 2..0, the count and `latch_value` hold.
- R11: `level_byte` shows the synchronized levels of A, B and C in bits 3, 4 and 5, with zeros elsewhere, two edges after an input change. Status bits 7..5 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_byte | input | 8 | Host control byte |
| preset_data | input | CNT_W | Value loaded on a preset edge |
| vr_mode | input | 1 | 1 = count/direction input mode |
| in_a | input | 1 | Track A (asynchronous) |
| in_b | input | 1 | Track B (asynchronous) |
| in_c | input | 1 | Zero-point pulse (asynchronous) |
| status_byte | output | 8 | Flags and acknowledges |
| count_value | output | CNT_W | Live count |
| latch_value | output | CNT_W | Captured count |
| level_byte | output | 8 | Synchronized input levels |

## Verification
A preset load and a latch capture can fall on the same clock edge. The two paths have different delays: the C pulse goes through the synchronizer, while the control byte is sampled directly. The bench therefore raises C, waits two clock edges, and only then raises control bit 2 together with bit 0. The capture and the load then land on one edge. The bench checks that the latch holds the count from before the load and that the count holds the new preset. A second overlap, a quadrature step and a load on one edge, is covered by the checker property on loads.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ctrl_byte,
  input  logic [CNT_W-1:0] preset_data,
  input  logic             vr_mode,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_c,
  output logic [7:0]       status_byte,
  output logic [CNT_W-1:0] count_value,
  output logic [CNT_W-1:0] latch_value,
  output logic [7:0]       level_byte
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [2:0]       sy [SYNC_STAGES];
  logic [2:0]       lv_d;
  logic [CNT_W-1:0] cnt, lat;
  logic             ovf, unf, ack, per_ack, lt_valid, cb2_d;

  wire [2:0] lv = sy[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= '0;
      lv_d <= '0;
    end else begin
      sy[0] <= {in_c, in_b, in_a};
      for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
      lv_d <= lv;
    end
  end

  wire ch_a    = lv[0] ^ lv_d[0];
  wire ch_b    = lv[1] ^ lv_d[1];
  wire q_step  = ch_a ^ ch_b;
  wire q_up    = lv[0] ^ lv_d[1];
  wire v_step  = lv[0] & ~lv_d[0];
  wire v_up    = ~lv[1];
  wire step    = vr_mode ? v_step : q_step;
  wire up      = vr_mode ? v_up : q_up;
  wire proc    = ~ctrl_byte[7];
  wire load    = proc & ctrl_byte[2] & ~cb2_d;
  wire c_rise  = lv[2] & ~lv_d[2];
  wire capture = proc & ctrl_byte[0] & ~vr_mode & ~lt_valid & c_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (load) begin
      cnt <= preset_data;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (step) begin
      if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_MAX) ovf <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_MIN) unf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb2_d    <= 1'b0;
      ack      <= 1'b0;
      per_ack  <= 1'b0;
      lat      <= '0;
      lt_valid <= 1'b0;
    end else begin
      cb2_d <= ctrl_byte[2];
      if (load)                     ack <= 1'b1;
      else if (proc && !ctrl_byte[2]) ack <= 1'b0;
      if (proc) per_ack <= ctrl_byte[1];
      if (capture) begin
        lat      <= cnt;
        lt_valid <= 1'b1;
      end else if (proc && !ctrl_byte[0]) begin
        lt_valid <= 1'b0;
      end
    end
  end

  assign count_value = cnt;
  assign latch_value = lat;
  assign status_byte = {3'b000, ovf, unf, ack, per_ack, lt_valid};
  assign level_byte  = {2'b00, lv[2], lv[1], lv[0], 3'b000};

endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctrl_byte,
  input logic [CNT_W-1:0] preset_data,
  input logic             vr_mode,
  input logic [7:0]       status_byte,
  input logic [CNT_W-1:0] latch_value,
  input logic [CNT_W-1:0] count_value
);

  a_r4_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_byte[7] && ctrl_byte[2] && !$past(ctrl_byte[2])) |=>
      (count_value == $past(preset_data) && !status_byte[4] && !status_byte[3] && status_byte[2]))
    else $error("a_r4_preset_load");

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[4] && !(!ctrl_byte[7] && ctrl_byte[2] && !$past(ctrl_byte[2]))) |=> status_byte[4])
    else $error("a_r3_ovf_sticky");

  a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_byte[7] && !ctrl_byte[2]) |=> !status_byte[2])
    else $error("a_r5_ack_drop");

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[0] && !ctrl_byte[7] && ctrl_byte[0]) |=> (status_byte[0] && $stable(latch_value)))
    else $error("a_r6_latch_hold");

  a_r7_unarm: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_byte[7] && !ctrl_byte[0]) |=> (!status_byte[0] && $stable(latch_value)))
    else $error("a_r7_unarm");

  a_r8_vr_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_mode && !status_byte[0]) |=> !status_byte[0])
    else $error("a_r8_vr_no_latch");

  a_r10_reg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_byte[7] |=> ($stable(status_byte[2:0]) && $stable(latch_value)))
    else $error("a_r10_reg_mode");

endmodule

bind quad_pos_counter quad_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .preset_data(preset_data),
  .vr_mode(vr_mode), .status_byte(status_byte), .latch_value(latch_value),
  .count_value(count_value)
);

// File: tb/tb_quad_pos_counter.sv
module tb_quad_pos_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctrl_byte = '0;
  logic [15:0] preset_data = '0;
  logic        vr_mode = 1'b0, in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
  logic [7:0]  status_byte, level_byte;
  logic [15:0] count_value, latch_value;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_pos_counter dut (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .preset_data(preset_data),
    .vr_mode(vr_mode), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .status_byte(status_byte), .count_value(count_value),
    .latch_value(latch_value), .level_byte(level_byte)
  );

  // {A, B, ovf, unf, count}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {2'b10, 2'b00, 16'h0001}, {2'b11, 2'b00, 16'h0002},
    {2'b01, 2'b00, 16'h0003}, {2'b00, 2'b00, 16'h0004},
    {2'b01, 2'b00, 16'h0003}, {2'b11, 2'b00, 16'h0002},
    {2'b10, 2'b00, 16'h0001}, {2'b00, 2'b00, 16'h0000},
    {2'b11, 2'b00, 16'h0000}, {2'b00, 2'b00, 16'h0000},
    {2'b01, 2'b01, 16'hFFFF}, {2'b00, 2'b11, 16'h0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_c();
    in_c = 1'b1; tick(4);
    in_c = 1'b0; tick(4);
  endtask

  task automatic pulse_a();
    in_a = 1'b1; tick(4);
    in_a = 1'b0; tick(4);
  endtask

  initial begin
    tick(3);
    chk("R1 count in reset", count_value, 0);
    chk("R1 status in reset", status_byte, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after release", {count_value, latch_value}, 0);
    chk("R1 level after release", level_byte, 0);

    for (int i = 0; i < NV; i++) begin
      in_a = VEC[i][19];
      in_b = VEC[i][18];
      tick(4);
      chk("R2 quadrature count", count_value, VEC[i][15:0]);
      chk("R3 wrap flags", {status_byte[4], status_byte[3]}, VEC[i][17:16]);
    end

    // R2 latency: third edge after change
    in_a = 1'b1; tick(2);
    chk("R2 not yet at edge 2", count_value, 16'h0000);
    tick(1);
    chk("R2 at edge 3", count_value, 16'h0001);

    // R11 levels
    in_c = 1'b1; tick(1);
    chk("R11 level before edge 2", level_byte, 8'h08);
    tick(1);
    chk("R11 level byte A,C", level_byte, 8'h28);
    chk("R11 status upper zero", status_byte[7:5], 0);
    in_c = 1'b0; in_a = 1'b0; in_b = 1'b1; tick(4);
    chk("R11 level byte B", level_byte, 8'h10);
    in_b = 1'b0; tick(4);

    // R4 / R5 preset
    preset_data = 16'h1234; ctrl_byte = 8'h04; tick(2);
    chk("R4 preset load", count_value, 16'h1234);
    chk("R4 flags cleared", {status_byte[4], status_byte[3]}, 0);
    chk("R5 ack set", status_byte[2], 1);
    preset_data = 16'h5555; tick(3);
    chk("R4 no reload on level", count_value, 16'h1234);
    chk("R5 ack held", status_byte[2], 1);
    ctrl_byte = 8'h00; tick(2);
    chk("R5 ack cleared", status_byte[2], 0);

    // R6 / R7 latch
    ctrl_byte = 8'h01; tick(2);
    pulse_c();
    chk("R6 first capture", latch_value, 16'h1234);
    chk("R6 valid set", status_byte[0], 1);
    in_a = 1'b1; tick(4);
    chk("R2 step before second C", count_value, 16'h1235);
    pulse_c();
    chk("R6 later pulse ignored", latch_value, 16'h1234);
    ctrl_byte = 8'h00; tick(2);
    chk("R7 valid cleared", status_byte[0], 0);
    chk("R7 latch kept", latch_value, 16'h1234);
    ctrl_byte = 8'h01; tick(2);
    pulse_c();
    chk("R7 rearmed capture", latch_value, 16'h1235);

    // R6 collision: capture and load on one edge
    ctrl_byte = 8'h00; tick(2);
    ctrl_byte = 8'h01; preset_data = 16'hABCD; tick(2);
    in_c = 1'b1; tick(2);
    ctrl_byte = 8'h05; tick(3);
    chk("R6 collision latch old count", latch_value, 16'h1235);
    chk("R4 collision count loaded", count_value, 16'hABCD);
    in_c = 1'b0; ctrl_byte = 8'h01; tick(3);

    // R9 period ack
    ctrl_byte = 8'h03; tick(1);
    chk("R9 period ack set", status_byte[1], 1);
    ctrl_byte = 8'h01; tick(1);
    chk("R9 period ack clear", status_byte[1], 0);

    // R10 register mode
    ctrl_byte = 8'h80; preset_data = 16'h0F0F; tick(3);
    chk("R10 valid held with bit0 low", status_byte[0], 1);
    ctrl_byte = 8'h86; tick(3);
    chk("R10 no preset", count_value, 16'hABCD);
    chk("R10 no acks", status_byte[2:1], 0);
    ctrl_byte = 8'h00; tick(2);

    // R8 count/direction mode
    in_a = 1'b0; tick(4);
    vr_mode = 1'b1; preset_data = 16'h0010; ctrl_byte = 8'h04; tick(2);
    ctrl_byte = 8'h01; tick(2);
    pulse_a();
    chk("R8 up on A with B low", count_value, 16'h0011);
    in_b = 1'b1; tick(4);
    chk("R8 B change no count", count_value, 16'h0011);
    pulse_a();
    chk("R8 down on A with B high", count_value, 16'h0010);
    pulse_c();
    chk("R8 latch disabled", status_byte[0], 0);
    chk("R8 latch value kept", latch_value, 16'h1235);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule